// File: doc/BRIEF.md
# Chip Select Access Timing Controller

This block times the chip-select strobes of an external asynchronous bus. A requester presents an access with a direction flag and a chip-select index. The block picks the configuration word of that select and drives its active-low strobe for a computed number of clocks. When the strobe returns high it raises a one-cycle completion pulse. It then holds every strobe negated for a programmed recovery gap before it takes the next access.

Each select has its own configuration word, written through a small configuration port and read back combinationally. The word carries five things:
- a 6-bit wait code, which sets the length through a nonlinear mapping;
- a 3-bit count of extra clocks for writes;
- a 2-bit recovery gap;
- a bypass flag that drops the gap after writes;
- a reserved bit that always reads as zero.

On the acknowledge-capable select (index 5), the all-ones wait code ends the access on an external acknowledge input instead of a count. Only one access runs at a time. A request that arrives while the block is busy or recovering sees `ready` low and is held off.

Top module: `cstc_top`

## Requirements
- R1: A read on a select whose wait code w is 0 or 1 keeps that select's strobe low for exactly 2 clocks. Any other w gives w+1 clocks: 14 gives 15, 62 gives 63.
- R2: A write keeps the strobe low for the R1 length plus the select's extra-write count (0 to 7). The extra-write count does not change the length of a read.
- R3: After a counted or acknowledged access ends, every strobe stays high and `ready` stays low for exactly G clocks, where G is the select's gap code (0 to 3). `ready` then rises.
- R4: When the select's bypass flag is set, a write ends with no recovery gap. A read on the same select still waits G clocks.
- R5: On select 5 with wait code 63, the strobe stays low until `ack_in` is sampled high on a rising edge. The strobe negates at that edge. No extra-write count applies.
- R6: On any select other than 5, wait code 63 counts 64 clocks, and `ack_in` has no effect.
- R7: `done` is high for exactly one clock, the first clock after each access in which the strobe is high again.
- R8: At most one bit of `cs_n` is low at any time. All bits are high whenever `ready` is high.
- R9: After reset, select 0 reads back wait code 62 and selects 1 to 5 read back wait code 0. All other fields read back 0. The word layout is: gap in bits [12:11], wait code in [10:5], reserved in [4], extra-write count in [3:1], bypass in [0]. Select 0 therefore reads 13'd1984 and the others read 0.
- R10: Bit 4 of `cfg_rdata` reads 0 even after a write that sets it. The other fields written alongside it are kept.
- R11: A request held high while `ready` is low is not started. It is accepted on the first rising edge at which `ready` is high, and the strobe goes low in the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Select whose word is written or read |
| cfg_wdata | input | 13 | Configuration word to write |
| cfg_rdata | output | 13 | Configuration word of `cfg_sel`, reserved bit forced to 0 |
| req | input | 1 | Access request, held until accepted |
| req_write | input | 1 | 1 = write access, 0 = read |
| req_cs | input | 3 | Target select index, 0 to 5 |
| ready | output | 1 | High when a request would be accepted at the next edge |
| ack_in | input | 1 | External transfer acknowledge for the acknowledge-terminated mode |
| cs_n | output | 6 | Active-low chip-select strobes |
| done | output | 1 | One-clock pulse after each access ends |

## Verification
A request is taken at the rising edge where `req` and `ready` are both high. The selected `cs_n` bit goes low in the cycle after that edge and stays low for the R1/R2 length, or until the edge where `ack_in` is seen high. `done` is due in the first cycle after that with the strobe high again. `ready` is due exactly G cycles later. `cfg_rdata` is combinational and due in the same cycle as `cfg_sel`.

The bench keeps a behavioural integer model that advances on each rising edge using the same sampled inputs. It compares `cs_n`, `ready` and `done` against the model on every falling edge. Every cycle of length, gap, stall and pulse is therefore checked at the exact clock it is due.

// File: rtl/cstc_pkg.sv
package cstc_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_ACT  = 2'd1,
      ST_GAP  = 2'd2
   } seq_state_e;
endpackage

// File: rtl/cstc_cfg_bank.sv
module cstc_cfg_bank #(
   parameter int NUM_CS       = 6,
   parameter int WAIT_W       = 6,
   parameter int XW_W         = 3,
   parameter int GAP_W        = 2,
   parameter int CS0_RST_WAIT = 62,
   parameter int SEL_W        = 3,
   parameter int WORD_W       = 13
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [SEL_W-1:0]  wsel,
   input  logic [WORD_W-1:0] wdata,
   input  logic [SEL_W-1:0]  rsel,
   output logic [WORD_W-1:0] rdata,
   input  logic [SEL_W-1:0]  lsel,
   output logic [WAIT_W-1:0] l_wait,
   output logic [XW_W-1:0]   l_xw,
   output logic [GAP_W-1:0]  l_gap,
   output logic              l_byp
);
   localparam int BYP_B    = 0;
   localparam int XW_LSB   = 1;
   localparam int RSV_B    = XW_LSB + XW_W;
   localparam int WAIT_LSB = RSV_B + 1;
   localparam int GAP_LSB  = WAIT_LSB + WAIT_W;

   if (GAP_LSB + GAP_W != WORD_W) begin : g_bad_word
      $error("cstc_cfg_bank: WORD_W does not match field widths");
   end

   logic [WAIT_W-1:0] wait_r [NUM_CS];
   logic [XW_W-1:0]   xw_r   [NUM_CS];
   logic [GAP_W-1:0]  gap_r  [NUM_CS];
   logic              byp_r  [NUM_CS];

   for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
      localparam logic [WAIT_W-1:0] RST_W = (i == 0) ? WAIT_W'(CS0_RST_WAIT) : '0;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            wait_r[i] <= RST_W;
            xw_r[i]   <= '0;
            gap_r[i]  <= '0;
            byp_r[i]  <= 1'b0;
         end else if (we && wsel == SEL_W'(i)) begin
            wait_r[i] <= wdata[WAIT_LSB +: WAIT_W];
            xw_r[i]   <= wdata[XW_LSB +: XW_W];
            gap_r[i]  <= wdata[GAP_LSB +: GAP_W];
            byp_r[i]  <= wdata[BYP_B];
         end
      end
   end

   always_comb begin
      rdata  = '0;
      l_wait = '0;
      l_xw   = '0;
      l_gap  = '0;
      l_byp  = 1'b0;
      for (int i = 0; i < NUM_CS; i++) begin
         if (rsel == SEL_W'(i)) rdata = {gap_r[i], wait_r[i], 1'b0, xw_r[i], byp_r[i]};
         if (lsel == SEL_W'(i)) begin
            l_wait = wait_r[i];
            l_xw   = xw_r[i];
            l_gap  = gap_r[i];
            l_byp  = byp_r[i];
         end
      end
   end
endmodule

// File: rtl/cstc_len_calc.sv
module cstc_len_calc #(
   parameter int WAIT_W = 6,
   parameter int XW_W   = 3,
   parameter int GAP_W  = 2,
   parameter int SEL_W  = 3,
   parameter int LEN_W  = 8,
   parameter int ACK_CS = 5,
   parameter bit ACK_EN = 1'b1
) (
   input  logic [SEL_W-1:0]  cs_idx,
   input  logic              is_write,
   input  logic [WAIT_W-1:0] wait_code,
   input  logic [XW_W-1:0]   xw,
   input  logic [GAP_W-1:0]  gap,
   input  logic              byp,
   output logic [LEN_W-1:0]  len,
   output logic              ack_mode,
   output logic [GAP_W-1:0]  eff_gap
);
   logic [LEN_W-1:0] base_len;

   always_comb begin
      base_len = (wait_code <= WAIT_W'(1)) ? LEN_W'(2) : LEN_W'(wait_code) + LEN_W'(1);
      len      = base_len + (is_write ? LEN_W'(xw) : LEN_W'(0));
      eff_gap  = (is_write && byp) ? '0 : gap;
   end

   if (ACK_EN) begin : g_ack
      assign ack_mode = (cs_idx == SEL_W'(ACK_CS)) && (wait_code == {WAIT_W{1'b1}});
   end else begin : g_no_ack
      assign ack_mode = 1'b0;
   end
endmodule

// File: rtl/cstc_seq.sv
module cstc_seq
   import cstc_pkg::*;
#(
   parameter int NUM_CS = 6,
   parameter int SEL_W  = 3,
   parameter int LEN_W  = 8,
   parameter int GAP_W  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_ok,
   input  logic [SEL_W-1:0]  req_cs,
   input  logic [LEN_W-1:0]  len,
   input  logic              ack_mode,
   input  logic [GAP_W-1:0]  eff_gap,
   input  logic              ack_in,
   output logic              ready,
   output logic [NUM_CS-1:0] cs_n,
   output logic              done
);
   seq_state_e        state;
   logic [LEN_W-1:0]  cnt;
   logic [GAP_W-1:0]  gcnt;
   logic [GAP_W-1:0]  gap_q;
   logic              ack_q;
   logic              finish;
   logic [NUM_CS-1:0] sel_oh;

   always_comb begin
      for (int i = 0; i < NUM_CS; i++) sel_oh[i] = (req_cs == SEL_W'(i));
   end

   assign ready  = (state == ST_IDLE);
   assign finish = ack_q ? ack_in : (cnt == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         cnt   <= '0;
         gcnt  <= '0;
         gap_q <= '0;
         ack_q <= 1'b0;
         cs_n  <= '1;
         done  <= 1'b0;
      end else begin
         done <= 1'b0;
         case (state)
            ST_IDLE: if (req_ok) begin
               state <= ST_ACT;
               cs_n  <= ~sel_oh;
               cnt   <= len - LEN_W'(1);
               ack_q <= ack_mode;
               gap_q <= eff_gap;
            end
            ST_ACT: if (finish) begin
               cs_n <= '1;
               done <= 1'b1;
               if (gap_q != '0) begin
                  state <= ST_GAP;
                  gcnt  <= gap_q - GAP_W'(1);
               end else begin
                  state <= ST_IDLE;
               end
            end else begin
               cnt <= cnt - LEN_W'(1);
            end
            ST_GAP: if (gcnt == '0) state <= ST_IDLE;
                    else gcnt <= gcnt - GAP_W'(1);
            default: state <= ST_IDLE;
         endcase
      end
   end

   p_one_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~cs_n));
   p_idle_negated_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ready |-> (&cs_n));
   p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   p_done_negated_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (&cs_n));
   p_ack_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_ACT && ack_q && !ack_in) |=> (state == ST_ACT && !(&cs_n)));
   p_gap_blocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (done && gap_q != '0) |-> !ready);
endmodule

// File: rtl/cstc_top.sv
module cstc_top #(
   parameter int NUM_CS       = 6,
   parameter int WAIT_W       = 6,
   parameter int XW_W         = 3,
   parameter int GAP_W        = 2,
   parameter int ACK_CS       = 5,
   parameter bit ACK_EN       = 1'b1,
   parameter int CS0_RST_WAIT = 62,
   localparam int SEL_W       = (NUM_CS > 1) ? $clog2(NUM_CS) : 1,
   localparam int WORD_W      = GAP_W + WAIT_W + 1 + XW_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [SEL_W-1:0]  cfg_sel,
   input  logic [WORD_W-1:0] cfg_wdata,
   output logic [WORD_W-1:0] cfg_rdata,
   input  logic              req,
   input  logic              req_write,
   input  logic [SEL_W-1:0]  req_cs,
   output logic              ready,
   input  logic              ack_in,
   output logic [NUM_CS-1:0] cs_n,
   output logic              done
);
   localparam int LEN_W = ((WAIT_W > XW_W) ? WAIT_W : XW_W) + 2;

   if (NUM_CS < 2) begin : g_bad_n
      $error("cstc_top: NUM_CS must be at least 2");
   end
   if (CS0_RST_WAIT >= (1 << WAIT_W)) begin : g_bad_rst
      $error("cstc_top: CS0_RST_WAIT exceeds wait field");
   end
   if (ACK_EN && ACK_CS >= NUM_CS) begin : g_bad_ack
      $error("cstc_top: ACK_CS out of range");
   end

   logic [WAIT_W-1:0] l_wait;
   logic [XW_W-1:0]   l_xw;
   logic [GAP_W-1:0]  l_gap;
   logic              l_byp;
   logic [LEN_W-1:0]  len;
   logic              ack_mode;
   logic [GAP_W-1:0]  eff_gap;
   logic              req_ok;

   assign req_ok = req && (32'(req_cs) < NUM_CS);

   cstc_cfg_bank #(
      .NUM_CS(NUM_CS), .WAIT_W(WAIT_W), .XW_W(XW_W), .GAP_W(GAP_W),
      .CS0_RST_WAIT(CS0_RST_WAIT), .SEL_W(SEL_W), .WORD_W(WORD_W)
   ) u_bank (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .wsel(cfg_sel), .wdata(cfg_wdata),
      .rsel(cfg_sel), .rdata(cfg_rdata), .lsel(req_cs),
      .l_wait(l_wait), .l_xw(l_xw), .l_gap(l_gap), .l_byp(l_byp)
   );

   cstc_len_calc #(
      .WAIT_W(WAIT_W), .XW_W(XW_W), .GAP_W(GAP_W), .SEL_W(SEL_W),
      .LEN_W(LEN_W), .ACK_CS(ACK_CS), .ACK_EN(ACK_EN)
   ) u_len (
      .cs_idx(req_cs), .is_write(req_write), .wait_code(l_wait), .xw(l_xw),
      .gap(l_gap), .byp(l_byp), .len(len), .ack_mode(ack_mode), .eff_gap(eff_gap)
   );

   cstc_seq #(
      .NUM_CS(NUM_CS), .SEL_W(SEL_W), .LEN_W(LEN_W), .GAP_W(GAP_W)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .req_ok(req_ok), .req_cs(req_cs), .len(len),
      .ack_mode(ack_mode), .eff_gap(eff_gap), .ack_in(ack_in),
      .ready(ready), .cs_n(cs_n), .done(done)
   );
endmodule

// File: tb/tb_cstc_top.sv
module tb_cstc_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [2:0]  cfg_sel = '0;
   logic [12:0] cfg_wdata = '0;
   logic [12:0] cfg_rdata;
   logic        req = 1'b0;
   logic        req_write = 1'b0;
   logic [2:0]  req_cs = '0;
   logic        ready;
   logic        ack_in = 1'b0;
   logic [5:0]  cs_n;
   logic        done;

   int errors = 0;
   int checks = 0;
   int cyc = 0;
   string tag = "R9";
   bit chk_on = 1'b0;

   int sh_wait [6];
   int sh_xw   [6];
   int sh_gap  [6];
   int sh_byp  [6];
   int m_phase, m_left, m_gleft, m_cs, m_gap;
   bit m_ack, m_done;

   always #10 clk = ~clk;

   cstc_top dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .req(req),
      .req_write(req_write), .req_cs(req_cs), .ready(ready), .ack_in(ack_in),
      .cs_n(cs_n), .done(done)
   );

   task automatic check(input string r, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", r, act, exp, cyc);
      end
   endtask

   // Reference model: advances on every rising edge
   always @(posedge clk) begin
      cyc++;
      if (!rst_n) begin
         for (int i = 0; i < 6; i++) begin
            sh_wait[i] = (i == 0) ? 62 : 0;
            sh_xw[i] = 0; sh_gap[i] = 0; sh_byp[i] = 0;
         end
         m_phase = 0; m_done = 0; m_left = 0; m_gleft = 0; m_cs = 0; m_ack = 0; m_gap = 0;
      end else begin
         m_done = 0;
         if (m_phase == 0) begin
            if (req && req_cs < 6) begin
               int w;
               w = sh_wait[req_cs];
               m_cs = req_cs;
               m_left = ((w <= 1) ? 2 : w + 1) + (req_write ? sh_xw[req_cs] : 0);
               m_ack = (req_cs == 5) && (w == 63);
               m_gap = (req_write && sh_byp[req_cs] != 0) ? 0 : sh_gap[req_cs];
               m_phase = 1;
            end
         end else if (m_phase == 1) begin
            bit fin;
            fin = m_ack ? ack_in : (m_left == 1);
            if (!m_ack) m_left--;
            if (fin) begin
               m_done = 1;
               if (m_gap > 0) begin m_phase = 2; m_gleft = m_gap; end
               else m_phase = 0;
            end
         end else begin
            m_gleft--;
            if (m_gleft == 0) m_phase = 0;
         end
         if (cfg_we && cfg_sel < 6) begin
            sh_byp[cfg_sel]  = cfg_wdata[0];
            sh_xw[cfg_sel]   = cfg_wdata[3:1];
            sh_wait[cfg_sel] = cfg_wdata[10:5];
            sh_gap[cfg_sel]  = cfg_wdata[12:11];
         end
      end
   end

   // Per-cycle comparison, away from the active edge
   always @(negedge clk) begin
      if (chk_on && rst_n) begin
         int exp_cs;
         exp_cs = (m_phase == 1) ? (~(1 << m_cs) & 6'h3f) : 6'h3f;
         check({tag, " strobe (R8)"}, cs_n, exp_cs);
         check({tag, " ready (R11)"}, ready, (m_phase == 0) ? 1 : 0);
         check({tag, " done (R7)"}, done, m_done);
      end
   end

   always @(posedge clk) begin
      if (cyc > 100000) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=%0d expected<=100000 cycles", cyc);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   function automatic logic [12:0] mk(int gap, int w, int xw, int byp);
      return {2'(gap), 6'(w), 1'b0, 3'(xw), 1'(byp)};
   endfunction

   task automatic cfg_write(input int sel, input logic [12:0] word);
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = 3'(sel); cfg_wdata = word;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic cfg_check(input string r, input int sel, input int exp);
      @(negedge clk);
      cfg_sel = 3'(sel);
      @(negedge clk);
      check(r, cfg_rdata, exp);
   endtask

   task automatic access(input int sel, input bit wr);
      @(negedge clk);
      req = 1'b1; req_write = wr; req_cs = 3'(sel);
      while (!ready) @(negedge clk);
      @(negedge clk);
      req = 1'b0;
   endtask

   task automatic settle();
      @(negedge clk);
      while (!ready) @(negedge clk);
      repeat (2) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      chk_on = 1'b1;
      // R9: reset values and layout
      tag = "R9";
      cfg_check("R9 cs0 word", 0, 1984);
      for (int i = 1; i < 6; i++) cfg_check("R9 cs word", i, 0);
      check("R9 ready after reset", ready, 1);
      check("R9 strobes after reset", cs_n, 6'h3f);

      // R1: nonlinear read length
      tag = "R1";
      access(0, 1'b0); settle();
      cfg_write(1, mk(0, 0, 0, 0)); access(1, 1'b0); settle();
      cfg_write(1, mk(0, 1, 0, 0)); access(1, 1'b0); settle();
      cfg_write(1, mk(0, 14, 7, 0)); access(1, 1'b0); settle();

      // R2: write extra clocks
      tag = "R2";
      cfg_write(2, mk(0, 3, 5, 0));
      access(2, 1'b1); settle();
      access(2, 1'b0); settle();
      cfg_write(1, mk(0, 0, 7, 0)); access(1, 1'b1); settle();

      // R3 / R11: gap hold with back-to-back requests stalled
      tag = "R3";
      cfg_write(3, mk(3, 2, 0, 0));
      access(3, 1'b0); access(3, 1'b0); settle();
      tag = "R11";
      cfg_write(3, mk(1, 0, 0, 0));
      access(3, 1'b0); access(4, 1'b0); access(3, 1'b1); settle();
      cfg_write(3, mk(2, 5, 2, 0));
      access(3, 1'b1); access(3, 1'b0); settle();

      // R4: bypass of gap on writes only
      tag = "R4";
      cfg_write(4, mk(2, 4, 1, 1));
      access(4, 1'b1); access(4, 1'b1); access(4, 1'b0); access(4, 1'b1); settle();

      // R5: acknowledge-terminated access on select 5
      tag = "R5";
      cfg_write(5, mk(1, 63, 6, 0));
      access(5, 1'b0);
      repeat (4) @(negedge clk);
      ack_in = 1'b1;
      @(negedge clk);
      ack_in = 1'b0;
      settle();
      access(5, 1'b1);
      repeat (9) @(negedge clk);
      ack_in = 1'b1;
      @(negedge clk);
      ack_in = 1'b0;
      settle();

      // R6: all-ones wait code on another select counts, ack ignored
      tag = "R6";
      cfg_write(2, mk(0, 63, 0, 0));
      ack_in = 1'b1;
      access(2, 1'b0); settle();
      ack_in = 1'b0;
      cfg_write(5, mk(0, 62, 0, 0));
      ack_in = 1'b1;
      access(5, 1'b0); settle();
      ack_in = 1'b0;

      // R10: reserved bit always reads zero
      tag = "R10";
      cfg_write(1, 13'b10_001101_1_101_1);
      cfg_check("R10 reserved cleared", 1, 13'b10_001101_0_101_1);
      access(1, 1'b1); settle();

      repeat (3) @(negedge clk);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule